// File: doc/BRIEF.md
# Pulse-Gated One-of-Eight Select Decoder

This block turns a small binary command field into a set of active-high select lines, of which at most one is high at a time. It is meant to sit next to a processor and produce per-device strobes for input, output or memory selection. The decode is not enabled by a plain pin. It is enabled by a stored enable bit, and two processor timing pulses set, clear or preserve that bit. A chip-enable input overrides both pulses, so several of these decoders can be stacked behind a first-level decode.

The model is fully synchronous. A fast system clock samples the chip enable, both pulse levels and the field through a configurable number of register stages. The enable bit and the registered select lines then update on the following edge. With the default field width of three bits there are eight select lines.

Top module: `io_sel_decoder`

## Requirements
- R1: While the enable bit is 1, the sampled field value k (read as an unsigned binary number) drives select bit k high. For example, 0 drives bit 0 and 7 drives bit 7.
- R2: While the enable bit is 0, every select line is low whatever the field holds.
- R3: A sampled chip enable of 0 clears the enable bit, whatever levels the two pulses have.
- R4: With chip enable 1 and both pulses low, the enable bit keeps its previous value.
- R5: With chip enable 1, pulse A low and pulse B high, the enable bit becomes 1.
- R6: With chip enable 1, pulse A high and pulse B low, the enable bit becomes 0.
- R7: With chip enable 1 and both pulses high, the enable bit becomes 1.
- R8: Inputs held before a rising edge appear on the select lines after exactly SYNC_STAGES+1 rising edges. The field and the pulse levels are sampled together.
- R9: A synchronous active-high reset clears the sampling stages, the enable bit and the select lines. The select lines stay low until a later set command has passed through the pipeline.
- R10: In no cycle is more than one select line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; everything samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip enable; 0 forces the enable bit clear |
| pulse_a_i | input | 1 | Timing pulse A level (clears the enable when it is high alone) |
| pulse_b_i | input | 1 | Timing pulse B level (sets the enable when it is high) |
| sel_i | input | SEL_W | Binary command field |
| sel_o | output | 2**SEL_W | Registered active-high select lines |

## Verification
The bench builds the decoder with the default three-bit field, which gives eight lines, and with SYNC_STAGES set to 2. The deeper sampling chain therefore exercises the latency rule at a depth other than the default. Every field value is swept through pulse sequences with chip enable both on and off. Random levels on all inputs, with occasional resets, then reach every set, clear, hold and override combination, including field changes while the enable is held.

// File: rtl/io_sel_pkg.sv
package io_sel_pkg;

  // Action taken on the stored enable bit for one sampled input set
  typedef enum logic [1:0] {
    EN_KEEP = 2'd0,
    EN_SET  = 2'd1,
    EN_CLR  = 2'd2,
    EN_OFF  = 2'd3
  } en_cmd_e;

  function automatic en_cmd_e cmd_of(input logic ce, input logic pa, input logic pb);
    en_cmd_e c;
    if (!ce) begin
      c = EN_OFF;
    end else begin
      unique case ({pa, pb})
        2'b00:   c = EN_KEEP;
        2'b01:   c = EN_SET;
        2'b10:   c = EN_CLR;
        default: c = EN_SET;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/io_sel_sampler.sv
module io_sel_sampler #(
  parameter int W      = 6,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] pipe [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_st
        if (s == 0) begin : g_first
          always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= d_i;
          end
        end else begin : g_next
          always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
          end
        end
      end
      assign q_o = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/io_sel_enable.sv
module io_sel_enable
  import io_sel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ce_i,
  input  logic pa_i,
  input  logic pb_i,
  output logic en_next_o,
  output logic en_q_o
);

  en_cmd_e cmd;

  always_comb begin
    cmd = cmd_of(ce_i, pa_i, pb_i);
    unique case (cmd)
      EN_KEEP: en_next_o = en_q_o;
      EN_SET:  en_next_o = 1'b1;
      EN_CLR:  en_next_o = 1'b0;
      default: en_next_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) en_q_o <= 1'b0;
    else     en_q_o <= en_next_o;
  end

endmodule

// File: rtl/io_sel_onehot.sv
module io_sel_onehot #(
  parameter int SEL_W   = 3,
  parameter int NUM_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               en_i,
  output logic [NUM_OUT-1:0] dec_o
);

  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
      localparam logic [SEL_W-1:0] CODE = k[SEL_W-1:0];
      assign dec_o[k] = en_i && (sel_i == CODE);
    end
  endgenerate

endmodule

// File: rtl/io_sel_decoder.sv
module io_sel_decoder #(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce_i,
  input  logic                    pulse_a_i,
  input  logic                    pulse_b_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [(1<<SEL_W)-1:0]   sel_o
);

  localparam int NUM_OUT = 1 << SEL_W;
  localparam int IN_W    = SEL_W + 3;

  logic [IN_W-1:0]    raw_w;
  logic [IN_W-1:0]    smp_w;
  logic               s_ce, s_pa, s_pb;
  logic [SEL_W-1:0]   s_sel;
  logic               en_next, en_q;
  logic [NUM_OUT-1:0] dec_w;
  logic [NUM_OUT-1:0] out_q;

  assign raw_w = {ce_i, pulse_a_i, pulse_b_i, sel_i};

  io_sel_sampler #(.W(IN_W), .STAGES(SYNC_STAGES)) smp_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_w),
    .q_o (smp_w)
  );

  assign {s_ce, s_pa, s_pb, s_sel} = smp_w;

  io_sel_enable en_i (
    .clk       (clk),
    .rst       (rst),
    .ce_i      (s_ce),
    .pa_i      (s_pa),
    .pb_i      (s_pb),
    .en_next_o (en_next),
    .en_q_o    (en_q)
  );

  io_sel_onehot #(.SEL_W(SEL_W), .NUM_OUT(NUM_OUT)) dec_i (
    .sel_i (s_sel),
    .en_i  (en_next),
    .dec_o (dec_w)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= dec_w;
  end

  assign sel_o = out_q;

endmodule

// File: rtl/io_sel_decoder_chk.sv
module io_sel_decoder_chk #(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               s_ce,
  input logic               s_pa,
  input logic               s_pb,
  input logic               en_q,
  input logic [NUM_OUT-1:0] sel_o
);

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o)); // R10

  AST_LINE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (sel_o != '0) |-> en_q); // R2

  AST_EN_DRIVES_ONE: assert property (@(posedge clk) disable iff (rst)
    en_q |-> ($countones(sel_o) == 1)); // R1

  AST_CE_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    !s_ce |=> !en_q); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (s_ce && !s_pa && !s_pb) |=> $stable(en_q)); // R4

  AST_SET_B_ONLY: assert property (@(posedge clk) disable iff (rst)
    (s_ce && !s_pa && s_pb) |=> en_q); // R5

  AST_CLR_A_ONLY: assert property (@(posedge clk) disable iff (rst)
    (s_ce && s_pa && !s_pb) |=> !en_q); // R6

  AST_SET_BOTH: assert property (@(posedge clk) disable iff (rst)
    (s_ce && s_pa && s_pb) |=> en_q); // R7

endmodule

bind io_sel_decoder io_sel_decoder_chk #(.NUM_OUT(NUM_OUT)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .s_ce  (s_ce),
  .s_pa  (s_pa),
  .s_pb  (s_pb),
  .en_q  (en_q),
  .sel_o (sel_o)
);

// File: tb/io_sel_decoder_tb_top.sv
`timescale 1ns/1ps
module io_sel_decoder_tb_top;

  localparam int SEL_W = 3;
  localparam int SYNC  = 2;
  localparam int NOUT  = 1 << SEL_W;
  localparam int WATCHDOG_CYCLES = 100000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ce = 1'b0, pa = 1'b0, pb = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [NOUT-1:0]  sel_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  io_sel_decoder #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .ce_i      (ce),
    .pulse_a_i (pa),
    .pulse_b_i (pb),
    .sel_i     (sel),
    .sel_o     (sel_o)
  );

  // Reference model built from the requirement list
  logic [SEL_W+2:0] m_pipe [SYNC];
  logic             m_en  = 1'b0;
  logic [NOUT-1:0]  m_out = '0;
  string            m_tag = "R9";

  function automatic logic [NOUT-1:0] exp_lines(input logic en, input logic [SEL_W-1:0] v);
    logic [NOUT-1:0] r;
    r = '0;
    if (en) r[v] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    logic c, a, b;
    logic [SEL_W-1:0] v;
    if (rst) begin
      for (int i = 0; i < SYNC; i++) m_pipe[i] = '0;
      m_en  = 1'b0;
      m_out = '0;
      m_tag = "R9";
    end else begin
      {c, a, b, v} = m_pipe[SYNC-1];
      if (!c)               begin m_en = 1'b0; m_tag = "R3"; end
      else if (!a && !b)    begin              m_tag = "R4"; end
      else if (!a &&  b)    begin m_en = 1'b1; m_tag = "R5"; end
      else if ( a && !b)    begin m_en = 1'b0; m_tag = "R6"; end
      else                  begin m_en = 1'b1; m_tag = "R7"; end
      m_out = exp_lines(m_en, v);
      for (int i = SYNC-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = {ce, pa, pb, sel};
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [NOUT-1:0] act, input logic [NOUT-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Continuous comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(sel_o === m_out, m_tag, sel_o, m_out);
      if (!m_en) chk(sel_o === '0, "R2", sel_o, '0);
      chk($countones(sel_o) <= 1, "R10", sel_o, m_out);
      if (m_en) chk(sel_o === m_out, "R1", sel_o, m_out);
    end
  end

  task automatic drive(input logic c, input logic a, input logic b, input logic [SEL_W-1:0] v);
    @(negedge clk);
    ce = c; pa = a; pb = b; sel = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(ce, 1'b0, 1'b0, sel);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd41017);
    // R9: reset clears the lines
    repeat (4) @(negedge clk);
    chk(sel_o === '0, "R9", sel_o, '0);
    rst = 1'b0;

    // R8: latency of a set command from a cleared state
    drive(1'b1, 1'b0, 1'b1, 3'd5);
    for (int e = 1; e <= SYNC; e++) begin
      @(negedge clk);
      chk(sel_o === '0, "R8", sel_o, '0);
    end
    @(negedge clk);
    chk(sel_o === 8'b0010_0000, "R8", sel_o, 8'b0010_0000);
    drive(1'b1, 1'b1, 1'b0, 3'd5);
    idle(SYNC + 2);
    chk(sel_o === '0, "R6", sel_o, '0);

    // Pulse sequences for every field value, chip enable on then off
    for (int c = 1; c >= 0; c--) begin
      for (int v = 0; v < NOUT; v++) begin
        drive(c[0], 1'b1, 1'b0, v[SEL_W-1:0]);
        drive(c[0], 1'b1, 1'b0, v[SEL_W-1:0]);
        drive(c[0], 1'b0, 1'b0, v[SEL_W-1:0]);
        drive(c[0], 1'b0, 1'b1, v[SEL_W-1:0]);
        drive(c[0], 1'b1, 1'b1, v[SEL_W-1:0]);
        drive(c[0], 1'b0, 1'b0, v[SEL_W-1:0]);
        idle(SYNC + 2);
        if (c == 1) chk(sel_o === exp_lines(1'b1, v[SEL_W-1:0]), "R4", sel_o,
                        exp_lines(1'b1, v[SEL_W-1:0]));
        else        chk(sel_o === '0, "R3", sel_o, '0);
      end
    end

    // R4 with field changes while held: the line follows the field
    drive(1'b1, 1'b0, 1'b1, 3'd0);
    for (int v = 0; v < NOUT; v++) drive(1'b1, 1'b0, 1'b0, v[SEL_W-1:0]);
    idle(SYNC + 2);
    chk(sel_o === exp_lines(1'b1, 3'd7), "R1", sel_o, exp_lines(1'b1, 3'd7));

    // Random levels with occasional reset
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      drive(r[0] | r[1], r[2], r[3], r[6:4]);
      if (r[15:8] == 8'd0) begin
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
      end
    end
    idle(SYNC + 2);
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired t=%0t actual=%0d expected=%0d", $time, 0, 1);
      finish_run();
    end
  end

endmodule